// File: doc/BRIEF.md
# Switchable-Width Stack Pointer with Interrupt Save Sequencer

This block holds the stack pointer of an 8-bit processor and drives the memory write port used for stack traffic. The pointer is two bytes wide, but a run-time configuration bit decides whether both bytes move together (wide mode) or only the low byte moves and wraps inside a 256-byte page (narrow mode). Software reaches the two pointer bytes and a small configuration register through a byte-wide register port. The same configuration register also holds a three-bit external-memory mode field, which the block presents to neighbouring logic.

The stack grows toward lower addresses. A push lowers the pointer first and writes the byte at the new address in the same cycle. A pop raises the pointer. When an interrupt is taken, the block captures the program counter and the status byte. It then writes them in three back-to-back cycles on its own, in this order: counter low byte, counter high byte, status. It raises a busy flag while the sequence runs and gives a one-cycle done pulse after the last write. While busy is high, the block ignores new push, pop, interrupt and pointer-write requests. After reset the processor's program counter starts at 1020H. The counter lives outside this block, so after reset the sequencer saves whatever value the pc input carries.

Top module: `stack_ptr_unit`

## Requirements
- R1: After reset, both pointer bytes read 00h, the configuration register reads 00h, and busy, irq_done and mem_we are all 0.
- R2: Register select 0 reads and writes the low pointer byte and select 1 the high pointer byte. Select 2 is the configuration register and select 3 reads 00h. Each byte can be written on its own in either width mode. A write appears on reg_rdata from the next cycle.
- R3: Configuration bit 6 selects the width: 1 is wide (16-bit) and 0 is narrow (8-bit). Bit 6 and bits 2..0 are stored. Bit 7 and bits 5..3 always read 0.
- R4: The mode field in configuration bits 2..0 takes only 000 (expansion off) and 110 (64 KB expansion). A write that carries any other code leaves the field unchanged, while bit 6 still takes the written value. mem_mode always shows the field.
- R5: In wide mode, an accepted push asserts mem_we in the same cycle. mem_addr is the pointer minus 1, taken modulo 2^16, and mem_wdata is push_data. From the next cycle the pointer reads as that lowered value, so 0000h wraps to FFFFh.
- R6: An accepted pop raises the pointer by 1 with no memory write. In wide mode it spans 16 bits. In narrow mode only the low byte changes and wraps from FFh to 00h. push_req has priority over pop_req when both arrive in the same cycle.
- R7: In narrow mode, a push or sequencer write lowers only the low byte, wrapping 00h to FFh. The high byte keeps its value and mem_addr is {00h, low byte minus 1}.
- R8: An interrupt request accepted while idle captures pc_in and status_in. In the next three cycles mem_we is 1 and the block writes, at successively lower pointer addresses, the counter low byte, then the counter high byte, then the status byte. The pointer ends 3 lower, or 3 lower in the low byte in narrow mode.
- R9: busy is 1 in exactly the three write cycles of the sequence. irq_done is a one-cycle pulse in the cycle right after the status write.
- R10: While busy is 1, push_req, pop_req, irq_req and pointer-byte writes are ignored. A push or pop in the cycle an interrupt request is accepted is also ignored. Configuration writes are always accepted.
- R11: A pointer-byte write while not busy has priority over a push or pop in the same cycle. The byte takes the written value and no memory write occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| reg_sel | input | 2 | Register select: 0 low pointer byte, 1 high pointer byte, 2 configuration |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Read data of the selected register (combinational) |
| push_req | input | 1 | Push one byte |
| push_data | input | 8 | Byte to push |
| pop_req | input | 1 | Pop one byte (pointer moves up) |
| irq_req | input | 1 | Interrupt entry request |
| pc_in | input | 16 | Program counter value to save |
| status_in | input | 8 | Status byte to save |
| busy | output | 1 | Interrupt save sequence in progress |
| irq_done | output | 1 | One-cycle pulse after the last save write |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | 16 | Memory write address |
| mem_wdata | output | 8 | Memory write data |
| mem_mode | output | 3 | External memory mode field |

## Verification
A wrong pointer value shows on mem_addr at the very next push or save write, and on reg_rdata at the next read of a pointer byte. A narrow-mode carry that leaks into the high byte therefore shows up within one stack operation. A sequencer that skips, repeats or reorders a state puts the wrong byte on mem_wdata in that same cycle. It also shifts the irq_done pulse and the busy window by at least one cycle, and a per-cycle comparison catches both. A mode field that takes a reserved code shows on mem_mode in the cycle after the write.

// File: rtl/stk_pkg.sv
package stk_pkg;
  localparam logic [1:0] REG_PTR_LO = 2'd0;
  localparam logic [1:0] REG_PTR_HI = 2'd1;
  localparam logic [1:0] REG_CFG    = 2'd2;

  localparam int unsigned CFG_WIDTH_BIT = 6;
  localparam int unsigned MODE_W        = 3;

  localparam logic [MODE_W-1:0] MODE_OFF = 3'b000;
  localparam logic [MODE_W-1:0] MODE_EXT = 3'b110;

  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_PCL  = 2'd1,
    SEQ_PCH  = 2'd2,
    SEQ_STS  = 2'd3
  } seq_state_t;
endpackage

// File: rtl/stk_cfg_reg.sv
module stk_cfg_reg
  import stk_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_wide,
  input  logic [MODE_W-1:0] wr_mode,
  output logic              wide_mode,
  output logic [MODE_W-1:0] mem_mode,
  output logic [DW-1:0]     cfg_rdata
);
  logic              wide_q, wide_d;
  logic [MODE_W-1:0] mode_q, mode_d;
  logic              mode_legal;

  always_comb begin
    mode_legal = (wr_mode == MODE_OFF) || (wr_mode == MODE_EXT);
    wide_d     = wide_q;
    mode_d     = mode_q;
    if (wr_en) begin
      wide_d = wr_wide;
      if (mode_legal) mode_d = wr_mode;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wide_q <= 1'b0;
      mode_q <= MODE_OFF;
    end else if (wr_en) begin
      wide_q <= wide_d;
      mode_q <= mode_d;
    end
  end

  always_comb begin
    cfg_rdata                = '0;
    cfg_rdata[CFG_WIDTH_BIT] = wide_q;
    cfg_rdata[MODE_W-1:0]    = mode_q;
  end

  assign wide_mode = wide_q;
  assign mem_mode  = mode_q;

  // R4: the stored field never holds a reserved code
  p_mode_legal_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_OFF) || (mode_q == MODE_EXT));

  // R4: a write with a reserved code keeps the previous field
  p_reserved_kept_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !mode_legal) |=> $stable(mode_q));
endmodule

// File: rtl/stk_ptr_core.sv
module stk_ptr_core #(
  parameter int unsigned DW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wide_mode,
  input  logic            lo_we,
  input  logic            hi_we,
  input  logic [DW-1:0]   wdata,
  input  logic            dec_en,
  input  logic            inc_en,
  output logic [2*DW-1:0] sp,
  output logic [2*DW-1:0] dec_addr
);
  localparam int unsigned SPW = 2 * DW;

  logic [DW-1:0]  lo_q, hi_q, lo_d, hi_d;
  logic [DW-1:0]  lo_m1, lo_p1;
  logic [SPW-1:0] full_m1, full_p1;
  logic           ld_en;

  always_comb begin
    lo_m1   = lo_q - 1'b1;
    lo_p1   = lo_q + 1'b1;
    full_m1 = {hi_q, lo_q} - 1'b1;
    full_p1 = {hi_q, lo_q} + 1'b1;
    lo_d    = lo_q;
    hi_d    = hi_q;
    if (lo_we || hi_we) begin
      if (lo_we) lo_d = wdata;
      if (hi_we) hi_d = wdata;
    end else if (dec_en) begin
      if (wide_mode) {hi_d, lo_d} = full_m1;
      else           lo_d         = lo_m1;
    end else if (inc_en) begin
      if (wide_mode) {hi_d, lo_d} = full_p1;
      else           lo_d         = lo_p1;
    end
  end

  assign ld_en = lo_we | hi_we | dec_en | inc_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q <= '0;
      hi_q <= '0;
    end else if (ld_en) begin
      lo_q <= lo_d;
      hi_q <= hi_d;
    end
  end

  assign sp       = {hi_q, lo_q};
  assign dec_addr = wide_mode ? full_m1 : {{DW{1'b0}}, lo_m1};

  // R5: wide decrement lowers the whole pointer by one, wrapping
  p_dec_wide_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_en && wide_mode && !lo_we && !hi_we) |=> (sp == $past(sp) - 1'b1));

  // R7: narrow decrement leaves the high byte alone
  p_dec_narrow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_en && !wide_mode && !lo_we && !hi_we) |=> $stable(hi_q));

  // R6: wide increment raises the whole pointer by one
  p_inc_wide_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_en && !dec_en && wide_mode && !lo_we && !hi_we) |=> (sp == $past(sp) + 1'b1));
endmodule

// File: rtl/stk_irq_seq.sv
module stk_irq_seq
  import stk_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            irq_req,
  input  logic [2*DW-1:0] pc_in,
  input  logic [DW-1:0]   status_in,
  output logic            busy,
  output logic            done,
  output logic            seq_we,
  output logic [DW-1:0]   seq_data
);
  localparam int unsigned SPW = 2 * DW;

  seq_state_t     state_q, state_d;
  logic [SPW-1:0] pc_q;
  logic [DW-1:0]  sts_q;
  logic           done_q, done_d;
  logic           cap_en;

  always_comb begin
    cap_en  = (state_q == SEQ_IDLE) && irq_req;
    state_d = state_q;
    done_d  = 1'b0;
    case (state_q)
      SEQ_IDLE: if (irq_req) state_d = SEQ_PCL;
      SEQ_PCL:  state_d = SEQ_PCH;
      SEQ_PCH:  state_d = SEQ_STS;
      SEQ_STS: begin
        state_d = SEQ_IDLE;
        done_d  = 1'b1;
      end
      default:  state_d = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q  <= '0;
      sts_q <= '0;
    end else if (cap_en) begin
      pc_q  <= pc_in;
      sts_q <= status_in;
    end
  end

  always_comb begin
    case (state_q)
      SEQ_PCL: seq_data = pc_q[DW-1:0];
      SEQ_PCH: seq_data = pc_q[SPW-1:DW];
      SEQ_STS: seq_data = sts_q;
      default: seq_data = '0;
    endcase
  end

  assign busy   = (state_q != SEQ_IDLE);
  assign seq_we = busy;
  assign done   = done_q;

  // R8: the high counter byte always follows the low one
  p_order_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SEQ_PCL) |=> (state_q == SEQ_PCH));

  // R9: done only in the cycle after the status write
  p_done_after_sts_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(state_q) == SEQ_STS));

  // R9: done and busy are never high together
  p_done_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  // R10: a request while busy never restarts the sequence
  p_no_restart_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && irq_req) |=> (state_q != SEQ_PCL));
endmodule

// File: rtl/stack_ptr_unit.sv
module stack_ptr_unit
  import stk_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        reg_sel,
  input  logic              reg_wr,
  input  logic [DW-1:0]     reg_wdata,
  output logic [DW-1:0]     reg_rdata,
  input  logic              push_req,
  input  logic [DW-1:0]     push_data,
  input  logic              pop_req,
  input  logic              irq_req,
  input  logic [2*DW-1:0]   pc_in,
  input  logic [DW-1:0]     status_in,
  output logic              busy,
  output logic              irq_done,
  output logic              mem_we,
  output logic [2*DW-1:0]   mem_addr,
  output logic [DW-1:0]     mem_wdata,
  output logic [MODE_W-1:0] mem_mode
);
  localparam int unsigned SPW = 2 * DW;

  logic           wide_mode;
  logic [DW-1:0]  cfg_rdata;
  logic           cfg_we, lo_we, hi_we;
  logic           move_ok, push_ok, pop_ok;
  logic           dec_en, inc_en;
  logic [SPW-1:0] sp, dec_addr;
  logic           seq_busy, seq_done, seq_we;
  logic [DW-1:0]  seq_data;

  always_comb begin
    cfg_we  = reg_wr && (reg_sel == REG_CFG);
    lo_we   = reg_wr && !seq_busy && (reg_sel == REG_PTR_LO);
    hi_we   = reg_wr && !seq_busy && (reg_sel == REG_PTR_HI);
    move_ok = !seq_busy && !irq_req && !lo_we && !hi_we;
    push_ok = push_req && move_ok;
    pop_ok  = pop_req && move_ok && !push_req;
    dec_en  = push_ok || seq_we;
    inc_en  = pop_ok;
  end

  stk_cfg_reg #(.DW(DW)) cfg_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (cfg_we),
    .wr_wide   (reg_wdata[CFG_WIDTH_BIT]),
    .wr_mode   (reg_wdata[MODE_W-1:0]),
    .wide_mode (wide_mode),
    .mem_mode  (mem_mode),
    .cfg_rdata (cfg_rdata)
  );

  stk_ptr_core #(.DW(DW)) ptr_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .wide_mode (wide_mode),
    .lo_we     (lo_we),
    .hi_we     (hi_we),
    .wdata     (reg_wdata),
    .dec_en    (dec_en),
    .inc_en    (inc_en),
    .sp        (sp),
    .dec_addr  (dec_addr)
  );

  stk_irq_seq #(.DW(DW)) seq_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .irq_req   (irq_req),
    .pc_in     (pc_in),
    .status_in (status_in),
    .busy      (seq_busy),
    .done      (seq_done),
    .seq_we    (seq_we),
    .seq_data  (seq_data)
  );

  always_comb begin
    case (reg_sel)
      REG_PTR_LO: reg_rdata = sp[DW-1:0];
      REG_PTR_HI: reg_rdata = sp[SPW-1:DW];
      REG_CFG:    reg_rdata = cfg_rdata;
      default:    reg_rdata = '0;
    endcase
  end

  assign mem_we    = dec_en;
  assign mem_addr  = dec_addr;
  assign mem_wdata = seq_we ? seq_data : push_data;
  assign busy      = seq_busy;
  assign irq_done  = seq_done;

  // R10: while busy, memory writes come only from the sequencer
  p_busy_owns_port_r10: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (mem_we && (mem_wdata == seq_data)));

  // R11: a pointer byte write blocks any stack movement that cycle
  p_write_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && !busy && (reg_sel == REG_PTR_LO || reg_sel == REG_PTR_HI)) |-> !mem_we);
endmodule

// File: tb/stack_ptr_unit_tb.sv
module stack_ptr_unit_tb_top;
  localparam time CLK_PERIOD = 10ns;
  localparam int  RAND_CYCLES = 4000;
  localparam int  WATCHDOG = 100000;

  logic        clk, rst_n;
  logic [1:0]  reg_sel;
  logic        reg_wr;
  logic [7:0]  reg_wdata, reg_rdata;
  logic        push_req, pop_req, irq_req;
  logic [7:0]  push_data, status_in;
  logic [15:0] pc_in;
  logic        busy, irq_done, mem_we;
  logic [15:0] mem_addr;
  logic [7:0]  mem_wdata;
  logic [2:0]  mem_mode;

  stack_ptr_unit dut_i (
    .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .push_req(push_req),
    .push_data(push_data), .pop_req(pop_req), .irq_req(irq_req),
    .pc_in(pc_in), .status_in(status_in), .busy(busy), .irq_done(irq_done),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_mode(mem_mode)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  // reference state
  logic [15:0] m_sp;
  logic        m_wide;
  logic [2:0]  m_mode;
  int          m_ph;
  logic        m_done;
  logic [15:0] m_pc;
  logic [7:0]  m_sts;

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [15:0] f_dec(logic [15:0] sp, logic wide);
    if (wide) return sp - 16'd1;
    return {8'h00, sp[7:0] - 8'd1};
  endfunction

  function automatic logic [15:0] f_step_dec(logic [15:0] sp, logic wide);
    if (wide) return sp - 16'd1;
    return {sp[15:8], sp[7:0] - 8'd1};
  endfunction

  function automatic logic [15:0] f_inc(logic [15:0] sp, logic wide);
    if (wide) return sp + 16'd1;
    return {sp[15:8], sp[7:0] + 8'd1};
  endfunction

  function automatic logic [7:0] f_read(logic [1:0] s, logic [15:0] sp, logic wide, logic [2:0] md);
    case (s)
      2'd0: return sp[7:0];
      2'd1: return sp[15:8];
      2'd2: return {1'b0, wide, 3'b000, md};
      default: return 8'h00;
    endcase
  endfunction

  task automatic step(input logic [1:0] s, input logic w, input logic [7:0] wd,
                      input logic pu, input logic [7:0] pd, input logic po,
                      input logic ir, input logic [15:0] pc, input logic [7:0] st);
    logic busy_e, ptr_wr, push_ok, pop_ok, we_e, acc;
    logic [7:0] data_e;
    logic [15:0] sp_n;
    logic wide_n;
    logic [2:0] mode_n;
    string tg;
    @(negedge clk);
    reg_sel = s; reg_wr = w; reg_wdata = wd; push_req = pu; push_data = pd;
    pop_req = po; irq_req = ir; pc_in = pc; status_in = st;
    #1;
    busy_e  = (m_ph != 0);
    acc     = ir && !busy_e;
    ptr_wr  = w && !busy_e && (s == 2'd0 || s == 2'd1);
    push_ok = pu && !busy_e && !ir && !ptr_wr;
    pop_ok  = po && !busy_e && !ir && !ptr_wr && !pu;
    we_e    = busy_e || push_ok;
    case (m_ph)
      1: data_e = m_pc[7:0];
      2: data_e = m_pc[15:8];
      3: data_e = m_sts;
      default: data_e = pd;
    endcase
    if (busy_e) tg = ((pu || po || ir || ptr_wr) ? "R10" : "R8");
    else if (w && (s == 2'd0 || s == 2'd1) && (pu || po)) tg = "R11";
    else if (acc && (pu || po)) tg = "R10";
    else if (pu) tg = (m_wide ? "R5" : "R7");
    else tg = "R6";
    chk(tg, "mem_we", mem_we, we_e);
    if (we_e) begin
      chk(busy_e ? "R8" : tg, "mem_addr", mem_addr, f_dec(m_sp, m_wide));
      chk(busy_e ? "R8" : tg, "mem_wdata", mem_wdata, data_e);
    end
    chk("R9", "busy", busy, busy_e);
    chk("R9", "irq_done", irq_done, m_done);
    chk((s == 2'd2) ? "R3" : "R2", "reg_rdata", reg_rdata, f_read(s, m_sp, m_wide, m_mode));
    chk("R4", "mem_mode", mem_mode, m_mode);
    // next reference state
    sp_n = m_sp; wide_n = m_wide; mode_n = m_mode;
    if (ptr_wr) begin
      if (s == 2'd0) sp_n[7:0] = wd; else sp_n[15:8] = wd;
    end else if (we_e) sp_n = f_step_dec(m_sp, m_wide);
    else if (pop_ok) sp_n = f_inc(m_sp, m_wide);
    if (w && s == 2'd2) begin
      wide_n = wd[6];
      if (wd[2:0] == 3'b000 || wd[2:0] == 3'b110) mode_n = wd[2:0];
    end
    @(posedge clk);
    m_done = (m_ph == 3);
    if (acc) begin m_ph = 1; m_pc = pc; m_sts = st; end
    else if (m_ph == 3) m_ph = 0;
    else if (m_ph != 0) m_ph = m_ph + 1;
    m_sp = sp_n; m_wide = wide_n; m_mode = mode_n;
  endtask

  task automatic idle(input logic [1:0] s);
    step(s, 0, 8'h00, 0, 8'h00, 0, 0, 16'h1020, 8'h00);
  endtask

  task automatic wr(input logic [1:0] s, input logic [7:0] d);
    step(s, 1, d, 0, 8'h00, 0, 0, 16'h1020, 8'h00);
  endtask

  initial begin
    int cyc = 0;
    while (!finished && cyc < WATCHDOG) begin
      @(posedge clk);
      cyc++;
    end
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 0; reg_sel = 0; reg_wr = 0; reg_wdata = 0; push_req = 0; push_data = 0;
    pop_req = 0; irq_req = 0; pc_in = 16'h1020; status_in = 0;
    m_sp = 0; m_wide = 0; m_mode = 0; m_ph = 0; m_done = 0; m_pc = 0; m_sts = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    // R1 reset state
    #1;
    for (int i = 0; i < 3; i++) begin
      reg_sel = i[1:0]; #1;
      chk("R1", "reg_rdata after reset", reg_rdata, 8'h00);
    end
    chk("R1", "busy after reset", busy, 1'b0);
    chk("R1", "irq_done after reset", irq_done, 1'b0);
    chk("R1", "mem_we after reset", mem_we, 1'b0);

    // R3/R4 configuration
    wr(2'd2, 8'h46); idle(2'd2);
    wr(2'd2, 8'hFF); idle(2'd2);        // R4 reserved 111 kept, R3 zero bits
    wr(2'd2, 8'h03); idle(2'd2);        // R4 reserved 011 kept, width goes narrow
    wr(2'd2, 8'h40); idle(2'd2);        // R4 back to 000
    wr(2'd2, 8'hC6); idle(2'd2);        // wide, mode 110
    // R5 wrap 0000 -> FFFF
    wr(2'd0, 8'h00); wr(2'd1, 8'h00);
    step(2'd0, 0, 0, 1, 8'h5A, 0, 0, 0, 0); idle(2'd1); idle(2'd0);
    // R6 pop wraps back
    step(2'd0, 0, 0, 0, 0, 1, 0, 0, 0); idle(2'd1);
    // R7 narrow wrap, high byte kept
    wr(2'd2, 8'h00); wr(2'd1, 8'h12); wr(2'd0, 8'h00);
    step(2'd0, 0, 0, 1, 8'hA1, 0, 0, 0, 0); idle(2'd1); idle(2'd0);
    step(2'd0, 0, 0, 0, 0, 1, 0, 0, 0); idle(2'd0); idle(2'd1);
    // R8/R9/R10 interrupt sequence with blocked requests
    wr(2'd2, 8'h40); wr(2'd1, 8'h20); wr(2'd0, 8'h00);
    step(2'd0, 0, 0, 1, 8'h77, 0, 1, 16'h1020, 8'hA5);
    step(2'd0, 0, 0, 1, 8'h77, 0, 0, 0, 0);
    step(2'd0, 1, 8'h99, 0, 0, 1, 1, 16'hBEEF, 8'h11);
    step(2'd1, 0, 0, 0, 0, 0, 1, 0, 0);
    idle(2'd0); idle(2'd1);
    // R8 narrow sequence wrapping the low byte
    wr(2'd2, 8'h00); wr(2'd0, 8'h01);
    step(2'd0, 0, 0, 0, 0, 0, 1, 16'hC3D4, 8'h3C);
    repeat (4) idle(2'd0);
    // R11 pointer write beats push
    wr(2'd2, 8'h40);
    step(2'd0, 1, 8'h80, 1, 8'h44, 0, 0, 0, 0); idle(2'd0);
    step(2'd1, 1, 8'h33, 0, 0, 1, 0, 0, 0); idle(2'd1);

    // random mix
    for (int k = 0; k < RAND_CYCLES; k++) begin
      int r;
      logic [1:0] s;
      logic [7:0] d;
      logic w, pu, po, ir;
      r  = $urandom % 16;
      s  = 2'($urandom % 4);
      d  = 8'($urandom);
      w  = 0; pu = 0; po = 0; ir = 0;
      if (r < 4) pu = 1;
      else if (r < 7) po = 1;
      else if (r == 7) ir = 1;
      else if (r < 10) begin
        w = 1;
        if (s == 2'd2 && ($urandom % 2) == 0) d[2:0] = (($urandom % 2) == 0) ? 3'b110 : 3'b000;
      end
      if (($urandom % 8) == 0) pu = 1;
      if (($urandom % 8) == 0) po = 1;
      step(s, w, d, pu, 8'($urandom), po, ir, 16'($urandom), 8'($urandom));
    end
    repeat (4) idle(2'd0);
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule